// File: doc/BRIEF.md
# Byte-wide non-volatile memory command controller

This block sits behind a host register window. It lets software move single bytes to and from an 8 KB byte-addressed non-volatile memory. Software works through two registers. A data register holds the byte to store, or the byte that was fetched. A command register holds, in one word, the start/busy flag, the operation code, the byte address and a sticky timeout flag. Software places the byte in the data register first. It then writes the command word with the busy flag set, and polls the command register until busy drops.

On the memory side the controller raises a request and holds address, direction and write byte steady until the memory acknowledges. It counts the cycles it spends waiting. If no acknowledge arrives inside a parameterised window, it gives up, sets the timeout flag and clears busy. A `mem_present` input reports whether a memory is attached at all. With it low, no request is issued and every operation ends in timeout, so firmware can probe for the device at start-up.

Top module: `eep_cmd_ctrl`

## Requirements
- R1: After reset the command register reads 0, the data register reads 0 and `mem_req` is low.
- R2: Host offset 0x00 selects the command register and 0x04 selects the data register. Any other offset reads 0, and writes to it change neither register.
- R3: Command word layout: bit 31 busy/start, bits 29:28 operation (2'b11 write, any other value read), bit 17 timeout, bits 12:0 byte address. All other bits read 0. A write with bit 31 clear and bit 17 clear stores the operation and address without starting anything.
- R4: A command write with bit 31 set while idle sets busy and drives a request carrying the stored address, `mem_we` high only for operation 2'b11, and the data register's byte as `mem_wdata`.
- R5: A read that is acknowledged loads the fetched byte into data bits 7:0, with bits 31:8 zero, and clears busy in the acknowledge cycle.
- R6: A write that is acknowledged stores the data byte at the addressed location, clears busy and leaves the timeout flag 0.
- R7: With TMO_CYCLES as the limit, an acknowledge L cycles after the request appears (L < TMO_CYCLES) keeps busy visible for L+1 cycles. If no acknowledge arrives by cycle TMO_CYCLES-1, busy stays visible for TMO_CYCLES cycles, then clears with the timeout flag set and no change to the data register or the memory.
- R8: A command write with bit 31 clear and bit 17 set clears the timeout flag and starts no operation. A command write with both bits clear leaves the timeout flag unchanged.
- R9: Launching an operation clears a stale timeout flag.
- R10: While busy, host writes to either register are ignored. Reads stay legal.
- R11: With `mem_present` low, `mem_req` never rises, and every launched operation ends in timeout after TMO_CYCLES cycles.
- R12: While a request waits for acknowledge, `mem_addr`, `mem_we` and `mem_wdata` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | REG_AW | Host register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledge or timeout |
| mem_we | output | 1 | 1 = store byte, 0 = fetch byte |
| mem_addr | output | ADDR_BITS | Byte address |
| mem_wdata | output | 8 | Byte to store |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Fetched byte, valid with `mem_ack` |
| mem_present | input | 1 | Memory attached; low forces timeout |

## Verification
A wrong wait counter shows at the ports as a busy window of the wrong length: it is one cycle too long or too short, or the timeout flag disagrees with the acknowledge latency. The bench exposes this by sweeping the memory latency across and past the limit, one cycle at a time. A wrong stored address, direction or data byte appears as a mismatched byte on the next read-back of the same location, one operation later. A stuck sequencer state shows as busy that never clears within the polling cap, or as a request issued without a launch, which the bench sees within a few cycles of the offending write.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int CMD_BUSY_BIT = 31;
  localparam int CMD_OP_HI    = 29;
  localparam int CMD_OP_LO    = 28;
  localparam int CMD_TMO_BIT  = 17;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_DATA = 8'h04;

  localparam logic [1:0] OPC_WRITE = 2'b11;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_WAIT
  } seq_state_e;

  function automatic logic op_is_write(input logic [1:0] op);
    return op == OPC_WRITE;
  endfunction

  function automatic logic [31:0] cmd_pack(input logic        busy,
                                           input logic [1:0]  op,
                                           input logic        tmo,
                                           input logic [15:0] addr);
    logic [31:0] w;
    w = '0;
    w[CMD_BUSY_BIT]          = busy;
    w[CMD_OP_HI:CMD_OP_LO]   = op;
    w[CMD_TMO_BIT]           = tmo;
    w[15:0]                  = addr;
    return w;
  endfunction

  function automatic logic limit_reached(input logic [31:0] cnt, input int limit);
    return cnt == 32'(limit - 1);
  endfunction

endpackage

// File: rtl/eep_reg_decode.sv
module eep_reg_decode #(
  parameter int REG_AW = 8
) (
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              wr_busy_bit,
  input  logic              wr_tmo_bit,
  input  logic              busy,
  output logic              cmd_sel,
  output logic              data_sel,
  output logic              cmd_wr,
  output logic              data_wr,
  output logic              launch,
  output logic              probe_clr,
  output logic              host_data_poke
);
  import eep_pkg::*;

  logic accept;

  assign cmd_sel        = reg_addr == REG_AW'(OFS_CMD);
  assign data_sel       = reg_addr == REG_AW'(OFS_DATA);
  assign accept         = reg_wr && !busy;
  assign cmd_wr         = accept && cmd_sel;
  assign data_wr        = accept && data_sel;
  assign launch         = cmd_wr && wr_busy_bit;
  assign probe_clr      = cmd_wr && !wr_busy_bit && wr_tmo_bit;
  assign host_data_poke = reg_wr && data_sel;

endmodule

// File: rtl/eep_wait_timer.sv
module eep_wait_timer #(
  parameter int LIMIT = 2000,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  import eep_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  assign expired = run && limit_reached(32'(cnt_q), LIMIT);
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/eep_seq.sv
module eep_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic ack_ok,
  input  logic expired,
  output logic busy,
  output logic done_ok,
  output logic done_tmo
);
  import eep_pkg::*;

  seq_state_e st_q, st_d;

  assign busy     = st_q == SEQ_WAIT;
  assign done_ok  = busy && ack_ok;
  assign done_tmo = busy && !ack_ok && expired;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SEQ_IDLE: if (launch) st_d = SEQ_WAIT;
      SEQ_WAIT: if (done_ok || done_tmo) st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl #(
  parameter int REG_AW     = 8,
  parameter int ADDR_BITS  = 13,
  parameter int TMO_CYCLES = 2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic [7:0]           mem_wdata,
  input  logic                 mem_ack,
  input  logic [7:0]           mem_rdata,
  input  logic                 mem_present
);
  import eep_pkg::*;

  localparam int CNT_W = $clog2(TMO_CYCLES + 1);

  logic                 busy, done_ok, done_tmo, expired;
  logic                 cmd_sel, data_sel, cmd_wr, data_wr, launch, probe_clr;
  logic                 host_data_poke;
  logic [CNT_W-1:0]     wait_cnt;
  logic [1:0]           op_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic                 tmo_q;
  logic [7:0]           data_q;
  logic                 unused_wdata;

  assign unused_wdata = ^{reg_wdata[30], reg_wdata[27:18], reg_wdata[16:ADDR_BITS]};

  eep_reg_decode #(.REG_AW(REG_AW)) u_dec (
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .wr_busy_bit   (reg_wdata[CMD_BUSY_BIT]),
    .wr_tmo_bit    (reg_wdata[CMD_TMO_BIT]),
    .busy          (busy),
    .cmd_sel       (cmd_sel),
    .data_sel      (data_sel),
    .cmd_wr        (cmd_wr),
    .data_wr       (data_wr),
    .launch        (launch),
    .probe_clr     (probe_clr),
    .host_data_poke(host_data_poke)
  );

  eep_wait_timer #(.LIMIT(TMO_CYCLES), .CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .cnt    (wait_cnt),
    .expired(expired)
  );

  eep_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .ack_ok  (mem_ack && mem_present),
    .expired (expired),
    .busy    (busy),
    .done_ok (done_ok),
    .done_tmo(done_tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
    end else if (cmd_wr) begin
      op_q   <= reg_wdata[CMD_OP_HI:CMD_OP_LO];
      addr_q <= reg_wdata[ADDR_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     tmo_q <= 1'b0;
    else if (done_tmo)              tmo_q <= 1'b1;
    else if (launch || probe_clr)   tmo_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               data_q <= '0;
    else if (done_ok && !op_is_write(op_q))   data_q <= mem_rdata;
    else if (data_wr)                         data_q <= reg_wdata[7:0];
  end

  assign mem_req   = busy && mem_present;
  assign mem_we    = op_is_write(op_q);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  always_comb begin
    reg_rdata = '0;
    if (cmd_sel)       reg_rdata = cmd_pack(busy, op_q, tmo_q, 16'(addr_q));
    else if (data_sel) reg_rdata = {24'h0, data_q};
  end

endmodule

// File: rtl/eep_cmd_ctrl_chk.sv
module eep_cmd_ctrl_chk #(
  parameter int ADDR_BITS  = 13,
  parameter int TMO_CYCLES = 2000,
  parameter int CNT_W      = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 tmo_flag,
  input logic                 mem_req,
  input logic                 mem_ack,
  input logic                 mem_present,
  input logic                 mem_we,
  input logic [ADDR_BITS-1:0] mem_addr,
  input logic [7:0]           mem_wdata,
  input logic                 host_data_poke,
  input logic                 done_ok,
  input logic                 probe_clr,
  input logic [7:0]           data_q,
  input logic [CNT_W-1:0]     wait_cnt
);

  // R4
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R11
  no_req_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_present |-> !mem_req);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && busy) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7
  tmo_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> ($fell(busy) && $past(wait_cnt) == CNT_W'(TMO_CYCLES - 1)));

  // R10
  data_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_data_poke && !done_ok) |=> $stable(data_q));

  // R8
  probe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_clr |=> (!tmo_flag && !busy));

  // R5
  done_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> !busy);

endmodule

bind eep_cmd_ctrl eep_cmd_ctrl_chk #(
  .ADDR_BITS (ADDR_BITS),
  .TMO_CYCLES(TMO_CYCLES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .tmo_flag      (tmo_q),
  .mem_req       (mem_req),
  .mem_ack       (mem_ack),
  .mem_present   (mem_present),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .host_data_poke(host_data_poke),
  .done_ok       (done_ok),
  .probe_clr     (probe_clr),
  .data_q        (data_q),
  .wait_cnt      (wait_cnt)
);

// File: tb/eep_cmd_ctrl_tb.sv
module eep_cmd_ctrl_tb;
  localparam int TMO   = 8;
  localparam int ABITS = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [ABITS-1:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_present = 1'b1;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int mcnt   = 0;
  bit req_seen = 0;
  logic [7:0] store [int];

  always #5 clk = ~clk;

  eep_cmd_ctrl #(.REG_AW(8), .ADDR_BITS(ABITS), .TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_present(mem_present)
  );

  function automatic logic [7:0] seed_byte(int a);
    return 8'((a * 7) + (a >> 8) + 3);
  endfunction

  function automatic logic [7:0] peek(int a);
    if (store.exists(a)) return store[a];
    return seed_byte(a);
  endfunction

  function automatic logic [31:0] cmdw(logic busy, logic [1:0] op, logic tmo, int a);
    logic [31:0] w;
    w = '0;
    w[31] = busy; w[29:28] = op; w[17] = tmo; w[12:0] = a[12:0];
    return w;
  endfunction

  assign mem_ack = mem_req && (mcnt == lat);

  always @(posedge clk) begin
    if (mem_req) req_seen <= 1'b1;
    if (mem_req && !mem_ack) mcnt <= mcnt + 1;
    else mcnt <= 0;
    if (mem_req && mem_ack && mem_we) store[int'(mem_addr)] = mem_wdata;
  end

  always @(negedge clk) mem_rdata = peek(int'(mem_addr));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    for (int i = 0; i < 200; i++) begin
      reg_read(8'h00, v);
      if (!v[31]) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input int a, input int l, output int cyc);
    lat = l;
    reg_write(8'h00, cmdw(1'b1, op, 1'b0, a));
    wait_idle(cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  dreg;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(8'h00, v); chk(v == 0, "R1 cmd", v, 0);
    reg_read(8'h04, v); chk(v == 0, "R1 data", v, 0);
    chk(mem_req == 1'b0, "R1 req", {31'h0, mem_req}, 0);

    // R2 offsets
    reg_write(8'h04, 32'hFFFF_FF5A);
    reg_read(8'h04, v); chk(v == 32'h5A, "R2 data offset", v, 32'h5A);
    reg_read(8'h08, v); chk(v == 0, "R2 unmapped read", v, 0);
    reg_write(8'h08, 32'h3000_1FFF);
    reg_write(8'h0C, 32'hFFFF_FFFF);
    reg_read(8'h00, v); chk(v == 0, "R2 unmapped write cmd", v, 0);
    reg_read(8'h04, v); chk(v == 32'h5A, "R2 unmapped write data", v, 32'h5A);
    dreg = 8'h5A;

    // R3 layout, no start without bit 31
    req_seen = 0;
    reg_write(8'h00, cmdw(1'b0, 2'b11, 1'b0, 13'h1ABC) | 32'h4015_E000);
    repeat (3) @(negedge clk);
    reg_read(8'h00, v);
    chk(v == cmdw(1'b0, 2'b11, 1'b0, 13'h1ABC), "R3 readback", v, cmdw(1'b0, 2'b11, 1'b0, 13'h1ABC));
    chk(!req_seen, "R3 no start", {31'h0, req_seen}, 0);

    // R4 R5 R6 R7 latency sweep over both directions
    for (int l = 0; l <= TMO + 2; l++) begin
      for (int k = 0; k < 3; k++) begin
        int a;
        logic [7:0] wb, old;
        bit ok;
        a  = (k == 0) ? 0 : (k == 1) ? 8191 : ((l * 613 + 17) % 8192);
        ok = l < TMO;
        wb = 8'((l * 37) ^ (k * 91) ^ 8'hC3);
        old = peek(a);
        // write
        reg_write(8'h04, {24'h0, wb});
        run_op(2'b11, a, l, cyc);
        chk(cyc == (ok ? l + 1 : TMO), "R7 write busy window", cyc, ok ? l + 1 : TMO);
        reg_read(8'h00, v);
        chk(v == cmdw(1'b0, 2'b11, !ok, a), "R6 write status", v, cmdw(1'b0, 2'b11, !ok, a));
        // read back with short latency
        reg_write(8'h04, 32'h0000_0011);
        run_op(2'b00, a, 0, cyc);
        reg_read(8'h04, v);
        chk(v == {24'h0, ok ? wb : old}, "R4 R6 stored byte", v, {24'h0, ok ? wb : old});
        // read with the sweep latency
        dreg = 8'h11;
        reg_write(8'h04, 32'h0000_0022);
        dreg = 8'h22;
        run_op(2'b00, a, l, cyc);
        chk(cyc == (ok ? l + 1 : TMO), "R7 read busy window", cyc, ok ? l + 1 : TMO);
        reg_read(8'h04, v);
        chk(v == {24'h0, ok ? peek(a) : dreg}, "R5 R7 read data", v, {24'h0, ok ? peek(a) : dreg});
        reg_read(8'h00, v);
        chk(v[17] == !ok, "R7 timeout flag", {31'h0, v[17]}, {31'h0, !ok});
      end
    end

    // R8 probe clears timeout, starts nothing; plain write keeps it
    run_op(2'b00, 5, TMO + 3, cyc);
    reg_write(8'h00, cmdw(1'b0, 2'b00, 1'b0, 9));
    reg_read(8'h00, v); chk(v[17] == 1'b1, "R8 plain write keeps timeout", v, cmdw(1'b0, 2'b00, 1'b1, 9));
    req_seen = 0;
    reg_write(8'h00, cmdw(1'b0, 2'b00, 1'b1, 9));
    repeat (3) @(negedge clk);
    reg_read(8'h00, v); chk(v == cmdw(1'b0, 2'b00, 1'b0, 9), "R8 probe clears", v, cmdw(1'b0, 2'b00, 1'b0, 9));
    chk(!req_seen, "R8 probe no start", {31'h0, req_seen}, 0);

    // R9 launch clears stale timeout
    run_op(2'b00, 6, TMO + 3, cyc);
    run_op(2'b00, 6, 1, cyc);
    reg_read(8'h00, v); chk(v[17] == 1'b0, "R9 launch clears timeout", v, cmdw(1'b0, 2'b00, 1'b0, 6));

    // R10 writes during busy ignored; R12 request fields held
    reg_write(8'h04, 32'h0000_00A7);
    lat = 5;
    reg_write(8'h00, cmdw(1'b1, 2'b11, 1'b0, 1234));
    reg_write(8'h04, 32'h0000_00EE);
    reg_write(8'h00, cmdw(1'b0, 2'b00, 1'b0, 4321));
    wait_idle(cyc);
    reg_read(8'h00, v); chk(v == cmdw(1'b0, 2'b11, 1'b0, 1234), "R10 cmd ignored", v, cmdw(1'b0, 2'b11, 1'b0, 1234));
    reg_read(8'h04, v); chk(v == 32'hA7, "R10 data ignored", v, 32'hA7);
    chk(peek(1234) == 8'hA7, "R12 stored at held address", {24'h0, peek(1234)}, 32'hA7);
    chk(peek(4321) == seed_byte(4321), "R12 other address untouched", {24'h0, peek(4321)}, {24'h0, seed_byte(4321)});
    lat = TMO + 4;
    reg_write(8'h00, cmdw(1'b1, 2'b00, 1'b0, 77));
    reg_write(8'h00, cmdw(1'b0, 2'b00, 1'b1, 77));
    wait_idle(cyc);
    reg_read(8'h00, v); chk(v[17] == 1'b1, "R10 probe during busy ignored", v, cmdw(1'b0, 2'b00, 1'b1, 77));

    // R11 absent memory
    mem_present = 1'b0;
    req_seen = 0;
    run_op(2'b00, 100, 0, cyc);
    chk(cyc == TMO, "R11 absent window", cyc, TMO);
    reg_read(8'h00, v); chk(v[17] == 1'b1, "R11 absent timeout", v, cmdw(1'b0, 2'b00, 1'b1, 100));
    chk(!req_seen, "R11 no request", {31'h0, req_seen}, 0);
    mem_present = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule